// File: doc/BRIEF.md
# Coin Credit Accumulator with Fixed-Price Compare

This block sits on the coin-receiving side of a bottle vending machine. A coin sensor raises a strobe together with a 2-bit code for the coin type. The strobe can stay high for many cycles, but each coin is counted exactly once. The block keeps a running credit in units of ten cents. It compares the credit against a one-euro price held as a parameter.

Three mutually exclusive flags tell an external sequencing controller whether the credit is short of the price, equal to it, or above it. The controller clears the credit after a sale. While the credit is above the price, it pays out ten-cent coins and pulses a decrement command after each one, so the credit falls by one unit per coin paid.

Top module: `coin_credit_unit`

## Requirements
- R1: Coin code 2'b01 adds 1 unit, 2'b10 adds 5 units and 2'b11 adds 10 units; code 2'b00 adds nothing. The code is taken in the cycle the strobe rises, and `credit_o` shows the new value after the next rising clock edge.
- R2: A strobe that stays high adds its coin only once, even if the code changes while the strobe is high.
- R3: Exactly one of the three flags is high at any time: below when credit < 10, at when credit == 10, above when credit > 10.
- R4: A decrement command with nonzero credit subtracts exactly 1 unit. When it lands in the same cycle as a coin, both take effect.
- R5: A decrement command when the credit is zero has no effect.
- R6: A clear command sets the credit to 0 and wins over a coin or a decrement in the same cycle.
- R7: The credit saturates at 255 and never wraps.
- R8: `coin_present_o` is the coin strobe delayed by one clock cycle.
- R9: An active-low asynchronous reset gives credit 0, the below flag high and `coin_present_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coin_strobe_i | input | 1 | Coin sensor strobe, high while a coin passes |
| coin_code_i | input | 2 | Coin type code |
| clr_credit_i | input | 1 | Clear credit to zero |
| dec_credit_i | input | 1 | Take one ten-cent unit off the credit |
| credit_o | output | 8 | Current credit in ten-cent units |
| below_price_o | output | 1 | Credit is below the price |
| at_price_o | output | 1 | Credit equals the price |
| above_price_o | output | 1 | Credit is above the price |
| coin_present_o | output | 1 | Registered coin-present status |

## Verification
The bench holds strobes high across several cycles and changes the code while the strobe is high. A level-sensitive adder would count such a coin many times and overshoot the price. It steps the credit through 9, 10 and 11 to catch an off-by-one in the compare, which would make the flags disagree about the exact price. It stacks a clear on a coin and a decrement on a coin at zero credit. A wrong priority would leave stray credit, and an unguarded decrement would wrap to 255. It also drives the credit into the ceiling, where an unsaturated adder would wrap to a small value.

// File: rtl/coin_acc_pkg.sv
package coin_acc_pkg;
  typedef enum logic [1:0] {
    COIN_NONE = 2'b00,
    COIN_10C  = 2'b01,
    COIN_50C  = 2'b10,
    COIN_1E   = 2'b11
  } coin_code_e;

  localparam int unsigned UNITS_10C = 1;
  localparam int unsigned UNITS_50C = 5;
  localparam int unsigned UNITS_1E  = 10;
endpackage

// File: rtl/coin_edge_det.sv
module coin_edge_det
  import coin_acc_pkg::*;
#(
  parameter int unsigned ADD_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [1:0]       code_i,
  output logic             present_o,
  output logic [ADD_W-1:0] add_o
);
  logic strobe_q;
  logic rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign rise      = strobe_i & ~strobe_q;
  assign present_o = strobe_q;

  always_comb begin
    add_o = '0;
    if (rise) begin
      unique case (coin_code_e'(code_i))
        COIN_10C: add_o = ADD_W'(UNITS_10C);
        COIN_50C: add_o = ADD_W'(UNITS_50C);
        COIN_1E:  add_o = ADD_W'(UNITS_1E);
        default:  add_o = '0;
      endcase
    end
  end

  // held strobe must not add again
  assert_once_per_coin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_o && strobe_i) |-> (add_o == '0));
  assert_present_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> present_o);
endmodule

// File: rtl/credit_reg.sv
module credit_reg #(
  parameter int unsigned CREDIT_W = 8,
  parameter int unsigned ADD_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                dec_i,
  input  logic [ADD_W-1:0]    add_i,
  output logic [CREDIT_W-1:0] credit_o
);
  localparam int unsigned SUM_W = CREDIT_W + 1;
  localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'({CREDIT_W{1'b1}});

  logic [CREDIT_W-1:0] credit_q;
  logic [SUM_W-1:0]    sum;
  logic [CREDIT_W-1:0] credit_d;

  always_comb begin
    sum = {1'b0, credit_q} + SUM_W'(add_i);
    if (dec_i && (credit_q != '0)) sum = sum - SUM_W'(1);
    credit_d = (sum > MAX_SUM) ? {CREDIT_W{1'b1}} : sum[CREDIT_W-1:0];
    if (clr_i) credit_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= '0;
    else         credit_q <= credit_d;
  end

  assign credit_o = credit_q;

  assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (credit_q == '0));
  assert_dec_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i && credit_q == '0 && add_i == '0) |=> (credit_q == '0));
  assert_dec_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i && credit_q != '0 && add_i == '0) |=> (credit_q == $past(credit_q) - 1'b1));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !clr_i && add_i == '0) |=> $stable(credit_q));
  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&credit_q && !dec_i && !clr_i) |=> (&credit_q));
endmodule

// File: rtl/price_cmp.sv
module price_cmp #(
  parameter int unsigned CREDIT_W    = 8,
  parameter int unsigned PRICE_UNITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CREDIT_W-1:0] credit_i,
  output logic                below_o,
  output logic                at_o,
  output logic                above_o
);
  localparam logic [CREDIT_W-1:0] PRICE = CREDIT_W'(PRICE_UNITS);

  assign below_o = credit_i < PRICE;
  assign at_o    = credit_i == PRICE;
  assign above_o = credit_i > PRICE;

  assert_one_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({below_o, at_o, above_o}) == 1);
endmodule

// File: rtl/coin_credit_unit.sv
module coin_credit_unit #(
  parameter int unsigned CREDIT_W    = 8,
  parameter int unsigned PRICE_UNITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                coin_strobe_i,
  input  logic [1:0]          coin_code_i,
  input  logic                clr_credit_i,
  input  logic                dec_credit_i,
  output logic [CREDIT_W-1:0] credit_o,
  output logic                below_price_o,
  output logic                at_price_o,
  output logic                above_price_o,
  output logic                coin_present_o
);
  localparam int unsigned ADD_W = $clog2(coin_acc_pkg::UNITS_1E + 1);

  logic [ADD_W-1:0] coin_add;

  coin_edge_det #(.ADD_W(ADD_W)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (coin_strobe_i),
    .code_i    (coin_code_i),
    .present_o (coin_present_o),
    .add_o     (coin_add)
  );

  credit_reg #(.CREDIT_W(CREDIT_W), .ADD_W(ADD_W)) u_credit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_credit_i),
    .dec_i    (dec_credit_i),
    .add_i    (coin_add),
    .credit_o (credit_o)
  );

  price_cmp #(.CREDIT_W(CREDIT_W), .PRICE_UNITS(PRICE_UNITS)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .credit_i (credit_o),
    .below_o  (below_price_o),
    .at_o     (at_price_o),
    .above_o  (above_price_o)
  );
endmodule

// File: tb/coin_credit_unit_tb.sv
`timescale 1ns/100ps
module coin_credit_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       coin_strobe_i = 1'b0;
  logic [1:0] coin_code_i = 2'b00;
  logic       clr_credit_i = 1'b0;
  logic       dec_credit_i = 1'b0;
  logic [7:0] credit_o;
  logic       below_price_o, at_price_o, above_price_o, coin_present_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  coin_credit_unit u_dut (
    .clk_i, .rst_ni, .coin_strobe_i, .coin_code_i, .clr_credit_i, .dec_credit_i,
    .credit_o, .below_price_o, .at_price_o, .above_price_o, .coin_present_o
  );

  // {clr, dec, strobe, code[1:0], expected credit[7:0]}
  localparam int NVEC = 25;
  localparam logic [12:0] VEC [NVEC] = '{
    13'h0501, 13'h0701, 13'h0001, 13'h0606, 13'h0006,
    13'h0406, 13'h0006, 13'h0507, 13'h0007, 13'h0508,
    13'h0008, 13'h0509, 13'h0009, 13'h050A, 13'h000A,
    13'h050B, 13'h080A, 13'h0809, 13'h1000, 13'h0800,
    13'h1700, 13'h0000, 13'h0F0A, 13'h0809, 13'h0E0D
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input int exp_credit);
    chk("R3 below", int'(below_price_o), int'(exp_credit < 10));
    chk("R3 at", int'(at_price_o), int'(exp_credit == 10));
    chk("R3 above", int'(above_price_o), int'(exp_credit > 10));
  endtask

  task automatic step(input logic clr, input logic dec, input logic stb, input logic [1:0] code);
    @(negedge clk_i);
    clr_credit_i = clr;
    dec_credit_i = dec;
    coin_strobe_i = stb;
    coin_code_i = code;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #7;
    // R9 reset state
    chk("R9 credit", int'(credit_o), 0);
    chk("R9 present", int'(coin_present_o), 0);
    chk("R9 below", int'(below_price_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // vector walk covering R1 R2 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:8]);
      chk($sformatf("R1/R2/R4/R5/R6 vec%0d credit", i), int'(credit_o), int'(VEC[i][7:0]));
      chk($sformatf("R8 vec%0d present", i), int'(coin_present_o), int'(VEC[i][10]));
      chk_flags(int'(VEC[i][7:0]));
    end

    // R7 saturation
    step(1'b1, 1'b0, 1'b0, 2'b00);
    for (int k = 0; k < 25; k++) begin
      step(1'b0, 1'b0, 1'b1, 2'b11);
      step(1'b0, 1'b0, 1'b0, 2'b00);
    end
    chk("R1 credit 250", int'(credit_o), 250);
    step(1'b0, 1'b0, 1'b1, 2'b11);
    step(1'b0, 1'b0, 1'b0, 2'b00);
    chk("R7 saturate", int'(credit_o), 255);
    step(1'b0, 1'b0, 1'b1, 2'b11);
    step(1'b0, 1'b0, 1'b0, 2'b00);
    chk("R7 stay max", int'(credit_o), 255);
    chk_flags(255);
    step(1'b0, 1'b1, 1'b0, 2'b00);
    chk("R4 dec from max", int'(credit_o), 254);

    // R2 long strobe with code change
    step(1'b1, 1'b0, 1'b0, 2'b00);
    step(1'b0, 1'b0, 1'b1, 2'b10);
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b1, 2'b11);
    chk("R2 long strobe", int'(credit_o), 5);

    // R9 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R9 async credit", int'(credit_o), 0);
    chk("R9 async present", int'(coin_present_o), 0);
    chk("R9 async below", int'(below_price_o), 1);
    coin_strobe_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule